// File: doc/BRIEF.md
# AXI Outstanding-Transaction Limiter

This block sits between an AXI-style slave port driven by user logic and a master port that leads into a system interconnect. The address, write-data, write-response and read-data channels all use valid/ready handshakes. Address, ID and burst-length fields are forwarded unchanged, and both sides share one clock and one data width. The data width `DATA_W` is fixed at build time to 32, 64 or 128 bits.

The limiter keeps one counter for reads and one for writes. A read stays outstanding from its address handshake until the read beat carrying the last flag completes. A write stays outstanding from its address handshake until its response completes. New read or write addresses are stalled when the matching per-direction cap is reached (`RD_MAX`, `WR_MAX`, 16 each by default), or when the combined count reaches `TOT_MAX` (32 by default). A one-bit control register switches issue to one transaction at a time. In that mode an address is accepted only while nothing at all is outstanding.

Top module: `axi_issue_limiter`

## Requirements
- R1: AR and AW address, ID (8 bits) and length fields reach the master port unchanged, and each address accepted on the slave port appears exactly once on the master port, in order.
- R2: The W, B and R channels pass through unchanged in both directions: valid, ready, data, strobe, ID, response and last flag.
- R3: The read count rises by one on each AR handshake and falls by one on each R handshake with RLAST=1. An R beat with RLAST=0 does not change it. An AR handshake and an RLAST handshake in the same cycle leave it unchanged. It never exceeds `RD_MAX` and never goes below zero.
- R4: The write count rises by one on each AW handshake and falls by one on each B handshake. Both in one cycle leave it unchanged. It never exceeds `WR_MAX` and never goes below zero.
- R5: While `RD_MAX` reads are outstanding, `s_arready` and `m_arvalid` stay low. In the cycle after an RLAST handshake frees a slot, a waiting AR is accepted.
- R6: While `WR_MAX` writes are outstanding, `s_awready` and `m_awvalid` stay low. In the cycle after a B handshake frees a slot, a waiting AW is accepted.
- R7: While reads plus writes equal `TOT_MAX`, no AR or AW is accepted or forwarded. When one slot is left and both AR and AW are valid, the AR is accepted and the AW waits.
- R8: With the issue mode at 1 (single), an AR or AW is accepted only when the read and write counts are both zero. If both are valid at that point, the AR is accepted and the AW waits.
- R9: The issue-mode bit is loaded from `cfg_single_in` on a clock edge where `cfg_we`=1 (1 = single, 0 = multiple). It holds its value when `cfg_we`=0 and is read back on `cfg_single`.
- R10: After reset, both counts are zero and the mode is multiple (`cfg_single`=0), so `s_arready` and `s_awready` follow the master-side ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Issue-mode register write enable |
| cfg_single_in | input | 1 | Issue-mode value to write (1 = single) |
| cfg_single | output | 1 | Issue-mode readback |
| s_arvalid | input | 1 | Slave read address valid |
| s_arready | output | 1 | Slave read address ready |
| s_araddr | input | 32 | Slave read address |
| s_arid | input | 8 | Slave read ID |
| s_arlen | input | 8 | Slave read burst length |
| m_arvalid | output | 1 | Master read address valid |
| m_arready | input | 1 | Master read address ready |
| m_araddr | output | 32 | Master read address |
| m_arid | output | 8 | Master read ID |
| m_arlen | output | 8 | Master read burst length |
| s_rvalid | output | 1 | Slave read data valid |
| s_rready | input | 1 | Slave read data ready |
| s_rid | output | 8 | Slave read data ID |
| s_rdata | output | DATA_W | Slave read data |
| s_rresp | output | 2 | Slave read response |
| s_rlast | output | 1 | Slave read last beat |
| m_rvalid | input | 1 | Master read data valid |
| m_rready | output | 1 | Master read data ready |
| m_rid | input | 8 | Master read data ID |
| m_rdata | input | DATA_W | Master read data |
| m_rresp | input | 2 | Master read response |
| m_rlast | input | 1 | Master read last beat |
| s_awvalid | input | 1 | Slave write address valid |
| s_awready | output | 1 | Slave write address ready |
| s_awaddr | input | 32 | Slave write address |
| s_awid | input | 8 | Slave write ID |
| s_awlen | input | 8 | Slave write burst length |
| m_awvalid | output | 1 | Master write address valid |
| m_awready | input | 1 | Master write address ready |
| m_awaddr | output | 32 | Master write address |
| m_awid | output | 8 | Master write ID |
| m_awlen | output | 8 | Master write burst length |
| s_wvalid | input | 1 | Slave write data valid |
| s_wready | output | 1 | Slave write data ready |
| s_wdata | input | DATA_W | Slave write data |
| s_wstrb | input | DATA_W/8 | Slave write byte strobes |
| s_wlast | input | 1 | Slave write last beat |
| m_wvalid | output | 1 | Master write data valid |
| m_wready | input | 1 | Master write data ready |
| m_wdata | output | DATA_W | Master write data |
| m_wstrb | output | DATA_W/8 | Master write byte strobes |
| m_wlast | output | 1 | Master write last beat |
| s_bvalid | output | 1 | Slave write response valid |
| s_bready | input | 1 | Slave write response ready |
| s_bid | output | 8 | Slave write response ID |
| s_bresp | output | 2 | Slave write response code |
| m_bvalid | input | 1 | Master write response valid |
| m_bready | output | 1 | Master write response ready |
| m_bid | input | 8 | Master write response ID |
| m_bresp | input | 2 | Master write response code |

## Verification
The bench is built with small caps (4 reads, 4 writes, 6 in total) so that every limit is reached quickly.

- **Read-beat release.** A read beat without the last flag must not free a read slot. A design that decremented on every beat would admit a fifth read early.
- **Same-cycle issue and completion.** An issue and a completion arrive in the same cycle, and the bench then shows the cap is hit exactly one issue later. A counter that dropped either event would drift off by one in one direction or the other.
- **Total cap.** The bench fills the combined cap with per-direction room left, then offers AR and AW in the same cycle with one slot remaining. A design that checked only per-direction caps, or let both through, would exceed the total.
- **Single mode.** With the mode set, the bench offers both address types at an idle point. A design that tested only its own direction's counter, or had no tie-break, would put two transactions in flight.

// File: rtl/issue_limiter_pkg.sv
package issue_limiter_pkg;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 8;
  localparam int LEN_W  = 8;
  localparam int RESP_W = 2;

  typedef enum logic {
    ISSUE_MULTI  = 1'b0,
    ISSUE_SINGLE = 1'b1
  } issue_mode_e;
endpackage

// File: rtl/issue_counter.sv
module issue_counter #(
  parameter int MAX = 16,
  parameter int W   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(MAX);

  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  // Only a lone issue or a lone completion moves the count.
  assign cnt_en = inc ^ dec;

  always_comb begin
    cnt_nxt = cnt;
    if (inc && !dec)      cnt_nxt = cnt + 1'b1;
    else if (dec && !inc) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R3 / R4: bounded count, no underflow, simultaneous events cancel
  a_r3_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);
  a_r3_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec && !inc && cnt == '0));
  a_r3_r4_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));
endmodule

// File: rtl/issue_mode_reg.sv
module issue_mode_reg
  import issue_limiter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_single_in,
  output issue_mode_e mode
);
  issue_mode_e mode_nxt;

  always_comb mode_nxt = cfg_single_in ? ISSUE_SINGLE : ISSUE_MULTI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode <= ISSUE_MULTI;
    else if (cfg_we) mode <= mode_nxt;
  end

  // R9: the mode changes only on a write
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode));
endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_limiter_pkg::*;
#(
  parameter int RD_MAX  = 16,
  parameter int WR_MAX  = 16,
  parameter int TOT_MAX = 32,
  parameter int CNT_W   = 5,
  parameter int TOT_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  issue_mode_e      mode,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             ar_req_in,
  output logic             ar_allow,
  output logic             aw_allow
);
  localparam logic [CNT_W-1:0] RD_LIM  = CNT_W'(RD_MAX);
  localparam logic [CNT_W-1:0] WR_LIM  = CNT_W'(WR_MAX);
  localparam logic [TOT_W-1:0] TOT_LIM = TOT_W'(TOT_MAX);

  logic [TOT_W-1:0] total;
  logic [TOT_W-1:0] total_after_ar;
  logic             idle;
  logic             ar_take;

  assign total          = TOT_W'(rd_cnt) + TOT_W'(wr_cnt);
  assign idle           = (rd_cnt == '0) && (wr_cnt == '0);
  assign ar_take        = ar_req_in && ar_allow;
  // Reads win the last free slot: an AR that is about to go claims it.
  assign total_after_ar = total + TOT_W'(ar_take);

  always_comb begin
    if (mode == ISSUE_SINGLE) begin
      ar_allow = idle;
      aw_allow = idle && !ar_take;
    end else begin
      ar_allow = (rd_cnt < RD_LIM) && (total < TOT_LIM);
      aw_allow = (wr_cnt < WR_LIM) && (total_after_ar < TOT_LIM);
    end
  end

  // R7: combined count bounded
  a_r7_total_cap: assert property (@(posedge clk) disable iff (!rst_n)
    total <= TOT_LIM);
  // R5 / R6: full direction admits nothing
  a_r5_read_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == RD_LIM) |-> !ar_allow);
  a_r6_write_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt == WR_LIM) |-> !aw_allow);
endmodule

// File: rtl/axi_issue_limiter.sv
module axi_issue_limiter
  import issue_limiter_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int RD_MAX  = 16,
  parameter int WR_MAX  = 16,
  parameter int TOT_MAX = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_single_in,
  output logic                cfg_single,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [ID_W-1:0]     s_arid,
  input  logic [LEN_W-1:0]    s_arlen,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [ID_W-1:0]     m_arid,
  output logic [LEN_W-1:0]    m_arlen,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ID_W-1:0]     s_rid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [RESP_W-1:0]   s_rresp,
  output logic                s_rlast,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [ID_W-1:0]     m_rid,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [RESP_W-1:0]   m_rresp,
  input  logic                m_rlast,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [LEN_W-1:0]    s_awlen,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [ID_W-1:0]     m_awid,
  output logic [LEN_W-1:0]    m_awlen,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     s_bid,
  output logic [RESP_W-1:0]   s_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [RESP_W-1:0]   m_bresp
);
  localparam int DIR_MAX = (RD_MAX > WR_MAX) ? RD_MAX : WR_MAX;
  localparam int CNT_W   = $clog2(DIR_MAX + 1);
  localparam int TOT_W   = $clog2(RD_MAX + WR_MAX + TOT_MAX + 2);
  localparam int N_DIR   = 2;  // index 0 = read, 1 = write

  issue_mode_e      mode;
  logic             ar_allow, aw_allow;
  logic [N_DIR-1:0] issue_ev, done_ev;
  logic [CNT_W-1:0] cnt [N_DIR];

  issue_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_single_in(cfg_single_in), .mode(mode)
  );
  assign cfg_single = (mode == ISSUE_SINGLE);

  // Per-direction outstanding counters
  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    issue_counter #(
      .MAX ((g == 0) ? RD_MAX : WR_MAX),
      .W   (CNT_W)
    ) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(issue_ev[g]), .dec(done_ev[g]), .cnt(cnt[g])
    );
  end

  issue_gate #(
    .RD_MAX(RD_MAX), .WR_MAX(WR_MAX), .TOT_MAX(TOT_MAX),
    .CNT_W(CNT_W), .TOT_W(TOT_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_cnt(cnt[0]), .wr_cnt(cnt[1]),
    .ar_req_in(s_arvalid),
    .ar_allow(ar_allow), .aw_allow(aw_allow)
  );

  // Address channels: handshake gated, payload forwarded
  assign m_arvalid = s_arvalid & ar_allow;
  assign s_arready = m_arready & ar_allow;
  assign m_araddr  = s_araddr;
  assign m_arid    = s_arid;
  assign m_arlen   = s_arlen;

  assign m_awvalid = s_awvalid & aw_allow;
  assign s_awready = m_awready & aw_allow;
  assign m_awaddr  = s_awaddr;
  assign m_awid    = s_awid;
  assign m_awlen   = s_awlen;

  // Data and response channels pass straight through
  assign m_wvalid = s_wvalid;
  assign s_wready = m_wready;
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_wlast  = s_wlast;

  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;
  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;

  assign s_rvalid = m_rvalid;
  assign m_rready = s_rready;
  assign s_rid    = m_rid;
  assign s_rdata  = m_rdata;
  assign s_rresp  = m_rresp;
  assign s_rlast  = m_rlast;

  // Counter events
  assign issue_ev[0] = m_arvalid & m_arready;
  assign done_ev[0]  = m_rvalid & s_rready & m_rlast;
  assign issue_ev[1] = m_awvalid & m_awready;
  assign done_ev[1]  = m_bvalid & s_bready;

  // R8: in single mode nothing issues while anything is in flight
  a_r8_single_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ISSUE_SINGLE && (cnt[0] != '0 || cnt[1] != '0))
      |-> !(m_arvalid || m_awvalid));
  // R8: never two issues in one cycle in single mode
  a_r8_single_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ISSUE_SINGLE) |-> !(issue_ev[0] && issue_ev[1]));
  // R1: a forwarded address always has a requester behind it
  a_r1_no_spurious_ar: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> s_arvalid);
endmodule

// File: tb/axi_issue_limiter_bench.sv
module axi_issue_limiter_bench;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;  // 250 MHz

  logic cfg_we, cfg_single_in, cfg_single;
  logic s_arvalid, s_arready, m_arvalid, m_arready;
  logic [31:0] s_araddr, m_araddr, s_awaddr, m_awaddr;
  logic [7:0]  s_arid, m_arid, s_arlen, m_arlen, s_awid, m_awid, s_awlen, m_awlen;
  logic s_rvalid, s_rready, s_rlast, m_rvalid, m_rready, m_rlast;
  logic [7:0] s_rid, m_rid, s_bid, m_bid;
  logic [DW-1:0] s_rdata, m_rdata, s_wdata, m_wdata;
  logic [1:0] s_rresp, m_rresp, s_bresp, m_bresp;
  logic s_awvalid, s_awready, m_awvalid, m_awready;
  logic s_wvalid, s_wready, s_wlast, m_wvalid, m_wready, m_wlast;
  logic [DW/8-1:0] s_wstrb, m_wstrb;
  logic s_bvalid, s_bready, m_bvalid, m_bready;

  axi_issue_limiter #(.DATA_W(DW), .RD_MAX(4), .WR_MAX(4), .TOT_MAX(6)) u_axi_issue_limiter (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [47:0] q_ar[$], q_aw[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitors: pop expected addresses as the master side takes them
  always @(posedge clk) begin
    if (rst_n && m_arvalid && m_arready) begin
      if (q_ar.size() == 0) chk("R1 unexpected AR", 1, 0);
      else chk("R1 AR payload", {m_araddr, m_arid, m_arlen}, q_ar.pop_front());
    end
    if (rst_n && m_awvalid && m_awready) begin
      if (q_aw.size() == 0) chk("R1 unexpected AW", 1, 0);
      else chk("R1 AW payload", {m_awaddr, m_awid, m_awlen}, q_aw.pop_front());
    end
  end

  task automatic ar_set(input logic [31:0] a, input logic [7:0] id, input logic [7:0] len);
    s_arvalid = 1'b1; s_araddr = a; s_arid = id; s_arlen = len;
    q_ar.push_back({a, id, len});
  endtask
  task automatic aw_set(input logic [31:0] a, input logic [7:0] id, input logic [7:0] len);
    s_awvalid = 1'b1; s_awaddr = a; s_awid = id; s_awlen = len;
    q_aw.push_back({a, id, len});
  endtask
  task automatic ar_fire(input logic [31:0] a, input logic [7:0] id, input string req);
    @(negedge clk); ar_set(a, id, 8'(id + 1)); #1 chk(req, s_arready, 1);
    @(negedge clk); s_arvalid = 1'b0;
  endtask
  task automatic aw_fire(input logic [31:0] a, input logic [7:0] id, input string req);
    @(negedge clk); aw_set(a, id, 8'(id + 2)); #1 chk(req, s_awready, 1);
    @(negedge clk); s_awvalid = 1'b0;
  endtask
  task automatic r_beat(input logic last);
    @(negedge clk);
    m_rvalid = 1'b1; m_rlast = last; m_rdata = 64'hDEAD_0000_0000_0000 | 64'(last);
    m_rid = 8'h3C; m_rresp = 2'b10;
    #1 chk("R2 R pass", {s_rvalid, s_rlast, s_rid, s_rresp, m_rready}, {1'b1, last, 8'h3C, 2'b10, 1'b1});
    chk("R2 R data", s_rdata, m_rdata);
    @(negedge clk); m_rvalid = 1'b0; m_rlast = 1'b0; #1;
  endtask
  task automatic b_beat();
    @(negedge clk);
    m_bvalid = 1'b1; m_bid = 8'h5A; m_bresp = 2'b01;
    #1 chk("R2 B pass", {s_bvalid, s_bid, s_bresp, m_bready}, {1'b1, 8'h5A, 2'b01, 1'b1});
    @(negedge clk); m_bvalid = 1'b0; #1;
  endtask
  task automatic cfg_write(input logic v);
    @(negedge clk); cfg_we = 1'b1; cfg_single_in = v;
    @(negedge clk); cfg_we = 1'b0; #1 chk("R9 mode readback", cfg_single, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_single_in = 0;
    s_arvalid = 0; s_araddr = 0; s_arid = 0; s_arlen = 0; m_arready = 1;
    s_awvalid = 0; s_awaddr = 0; s_awid = 0; s_awlen = 0; m_awready = 1;
    s_wvalid = 0; s_wdata = 0; s_wstrb = 0; s_wlast = 0; m_wready = 0;
    m_rvalid = 0; m_rid = 0; m_rdata = 0; m_rresp = 0; m_rlast = 0; s_rready = 1;
    m_bvalid = 0; m_bid = 0; m_bresp = 0; s_bready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R10: reset state
    chk("R10 arready", s_arready, 1);
    chk("R10 awready", s_awready, 1);
    chk("R10 no fwd", {m_arvalid, m_awvalid}, 0);
    chk("R10 mode multi", cfg_single, 0);

    // R5 / R3: fill reads, partial beat does not free, last beat does
    for (int i = 0; i < 4; i++) ar_fire(32'h1000 + 32'(i * 64), 8'(i), "R5 read below cap");
    @(negedge clk); ar_set(32'h2000, 8'h44, 8'h0F); #1;
    chk("R5 arready at cap", s_arready, 0);
    chk("R5 arvalid held back", m_arvalid, 0);
    r_beat(1'b0);
    chk("R3 non-last keeps count", s_arready, 0);
    r_beat(1'b1);
    chk("R5 freed slot accepts", s_arready, 1);
    @(negedge clk); s_arvalid = 1'b0;

    // R3: simultaneous issue and completion keep the count (3 stays 3)
    r_beat(1'b1);
    @(negedge clk); ar_set(32'h3000, 8'h51, 8'h01);
    m_rvalid = 1'b1; m_rlast = 1'b1; #1;
    chk("R3 issue with completion", s_arready, 1);
    @(negedge clk); s_arvalid = 1'b0; m_rvalid = 1'b0; m_rlast = 1'b0;
    ar_fire(32'h3100, 8'h52, "R3 count was three");
    @(negedge clk); ar_set(32'h3200, 8'h53, 8'h02); #1;
    chk("R3 count now four", s_arready, 0);
    r_beat(1'b1);
    @(negedge clk); s_arvalid = 1'b0;

    // R2: write data passes through
    @(negedge clk); s_wvalid = 1; s_wdata = 64'h0123_4567_89AB_CDEF; s_wstrb = 8'hA5; s_wlast = 1; m_wready = 1; #1;
    chk("R2 W pass", {m_wvalid, m_wlast, m_wstrb, s_wready}, {1'b1, 1'b1, 8'hA5, 1'b1});
    chk("R2 W data", m_wdata, 64'h0123_4567_89AB_CDEF);
    @(negedge clk); s_wvalid = 0; m_wready = 0;

    // R7: 4 reads + 2 writes fill the total cap
    aw_fire(32'h8000, 8'h70, "R7 write under total");
    aw_fire(32'h8040, 8'h71, "R7 write under total");
    @(negedge clk); aw_set(32'h8080, 8'h72, 8'h03); #1;
    chk("R7 total cap blocks AW", {s_awready, m_awvalid}, 0);
    b_beat();
    chk("R6 B frees write slot", s_awready, 1);
    @(negedge clk); s_awvalid = 1'b0;
    r_beat(1'b1);  // 3 reads + 2 writes, one slot left
    @(negedge clk); ar_set(32'h4000, 8'h60, 8'h04); aw_set(32'h9000, 8'h61, 8'h05); #1;
    chk("R7 read wins last slot", {s_arready, s_awready}, 2'b10);
    @(negedge clk); s_arvalid = 1'b0; #1;
    chk("R7 AW waits at total", s_awready, 0);
    b_beat();
    chk("R7 AW after B", s_awready, 1);
    @(negedge clk); s_awvalid = 1'b0;
    for (int i = 0; i < 4; i++) r_beat(1'b1);
    b_beat(); b_beat();

    // R6 / R4: write cap
    for (int i = 0; i < 4; i++) aw_fire(32'hA000 + 32'(i * 16), 8'(8'h80 + i), "R4 write below cap");
    @(negedge clk); aw_set(32'hB000, 8'h90, 8'h06); #1;
    chk("R6 awready at cap", {s_awready, m_awvalid}, 0);
    b_beat();
    chk("R6 freed write slot", s_awready, 1);
    @(negedge clk); s_awvalid = 1'b0;
    for (int i = 0; i < 4; i++) b_beat();

    // R8 / R9: single mode
    cfg_write(1'b1);
    ar_fire(32'hC000, 8'hC0, "R8 first read when idle");
    @(negedge clk); aw_set(32'hD000, 8'hD0, 8'h07); ar_set(32'hC100, 8'hC1, 8'h08); #1;
    chk("R8 both blocked while busy", {s_arready, s_awready}, 0);
    r_beat(1'b1);
    chk("R8 read wins when idle", {s_arready, s_awready}, 2'b10);
    @(negedge clk); s_arvalid = 1'b0; #1;
    chk("R8 AW waits for read", s_awready, 0);
    r_beat(1'b1);
    chk("R8 AW accepted when idle", s_awready, 1);
    @(negedge clk); s_awvalid = 1'b0;
    b_beat();
    cfg_write(1'b0);
    @(negedge clk); cfg_single_in = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R9 no write no change", cfg_single, 0);

    repeat (3) @(negedge clk);
    chk("R1 AR all forwarded", q_ar.size(), 0);
    chk("R1 AW all forwarded", q_aw.size(), 0);
    finish_run();
  end
endmodule